// File: doc/BRIEF.md
# Set/Clear Aliased Control Register Bank

This block is a peripheral register file that sits behind an APB-style slave port. Each control register that software updates often is reached at three word addresses. Writing the first address sets the bits where the write data holds ones. Writing the second address clears those bits. The third address reads back the stored value. A driver can therefore flip a single control bit with one store, and no read-modify-write sequence is needed. A small group of ordinary read/write registers sits beside the aliased ones. All register contents are driven straight out to the peripheral logic.

The bank answers only inside its own 16 Kbyte window. That window begins at the parameter `BASE_ADDR`, which must be aligned to 16 Kbyte. Within the window, aliased register k takes the 16-byte group at offset `k*0x10`. In that group, the set alias is at +0x0, the clear alias at +0x4 and the read alias at +0x8, while +0xC is left unmapped. Plain register j is at offset `PLAIN_OFF + 4*j`, with a default base of 0x100. Accesses complete with no wait states.

Top module: `sca_reg_bank`

## Requirements
- R1: While `rst_ni` is low, and on release of reset, every aliased and plain register holds zero. The asynchronous reset clears all of them.
- R2: A write to the set alias of register k (offset k*0x10) forces to one every bit of register k whose write-data bit is one.
- R3: A write to the clear alias of register k (offset k*0x10+0x4) forces to zero every bit of register k whose write-data bit is one.
- R4: In a set or clear write, bits whose write-data bit is zero keep their value. Registers other than the addressed one are unchanged.
- R5: A read of the read alias (offset k*0x10+0x8) returns the stored value of register k. Reads of the set alias and the clear alias return zero with no error.
- R6: A write to the read alias changes no register.
- R7: A plain register at `PLAIN_OFF + 4*j` takes the full write data, and a read of it returns that value.
- R8: An access to an unmapped offset raises `pslverr_o` in its access phase, reads as zero and changes no register. Unmapped offsets are offset +0xC of each alias group, offsets past the last group or the last plain register, and any address with bits [1:0] not zero.
- R9: An access whose address bits above bit 13 differ from those of `BASE_ADDR` is an error as in R8, and its write has no effect.
- R10: Registers change only on a write in the access phase (`psel_i` and `penable_i` both high). A setup phase alone leaves them unchanged.
- R11: `pready_o` is always high, so every access completes in its first access cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | AW (32) | Byte address |
| pwdata_i | input | DW (32) | Write data |
| prdata_o | output | DW (32) | Read data, zero when not reading |
| pready_o | output | 1 | Transfer ready, always high |
| pslverr_o | output | 1 | Error response for unmapped or out-of-window access |
| ctrl_o | output | N_ALIAS*DW (128) | Aliased register contents, register k in bits [k*DW +: DW] |
| plain_o | output | N_PLAIN*DW (64) | Plain register contents, register j in bits [j*DW +: DW] |

## Verification
The assertions assume that the bus master follows the two-phase protocol. That means `penable_i` rises only after a setup cycle with `psel_i` high, and address, data and direction stay steady across both phases. Under that assumption, at most one alias or plain register is targeted per cycle, so a set and a clear of the same bit never meet. The bench drives every transfer through a single task that holds setup for one cycle and access for one cycle, with all fields steady. It adds one deliberate setup-only cycle to show that a setup phase alone writes nothing.

// File: rtl/sca_pkg.sv
package sca_pkg;
  // slot within a 16-byte alias group, from address bits [3:2]
  typedef enum logic [1:0] {
    K_SET  = 2'd0,
    K_CLR  = 2'd1,
    K_RD   = 2'd2,
    K_NONE = 2'd3
  } alias_kind_e;
endpackage

// File: rtl/sca_decode.sv
module sca_decode
  import sca_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          WIN_BITS  = 14,
  parameter logic [31:0] BASE_ADDR = 32'hFFF8_4000,
  parameter int          N_ALIAS   = 4,
  parameter int          N_PLAIN   = 2,
  parameter int          PLAIN_OFF = 'h100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      paddr_i,
  output logic [N_ALIAS-1:0] hit_alias_o,
  output alias_kind_e        kind_o,
  output logic [N_PLAIN-1:0] hit_plain_o,
  output logic               err_o
);
  localparam int IDX_W = WIN_BITS - 4;

  logic [WIN_BITS-1:0] off;
  logic                in_win, aligned;

  assign off     = paddr_i[WIN_BITS-1:0];
  assign in_win  = paddr_i[AW-1:WIN_BITS] == BASE_ADDR[AW-1:WIN_BITS];
  assign aligned = off[1:0] == 2'b00;

  always_comb begin
    hit_alias_o = '0;
    hit_plain_o = '0;
    for (int k = 0; k < N_ALIAS; k++)
      if (in_win && aligned && off[WIN_BITS-1:4] == IDX_W'(k) && off[3:2] != 2'd3)
        hit_alias_o[k] = 1'b1;
    for (int j = 0; j < N_PLAIN; j++)
      if (in_win && off == WIN_BITS'(PLAIN_OFF + 4*j))
        hit_plain_o[j] = 1'b1;
  end

  assign kind_o = (|hit_alias_o) ? alias_kind_e'(off[3:2]) : K_NONE;
  assign err_o  = !((|hit_alias_o) || (|hit_plain_o));

  // R8: at most one register is addressed at a time
  a_r8_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hit_alias_o, hit_plain_o}));
  // R8: an error and a valid alias slot never coexist
  a_r8_err_no_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> kind_o == K_NONE);
endmodule

// File: rtl/sca_alias_reg.sv
module sca_alias_reg #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_we_i,
  input  logic          clr_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] set_m, clr_m;
  assign set_m = set_we_i ? wdata_i : '0;
  assign clr_m = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o | set_m) & ~clr_m;

  a_r2_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> (q_o & $past(wdata_i)) == $past(wdata_i));
  a_r3_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> (q_o & $past(wdata_i)) == '0);
  a_r4_zero_bits_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i || clr_we_i) |=> ((q_o ^ $past(q_o)) & ~$past(wdata_i)) == '0);
  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_we_i || clr_we_i) |=> $stable(q_o));
  a_r4_no_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_we_i && clr_we_i));
endmodule

// File: rtl/sca_plain_reg.sv
module sca_plain_reg #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;

  a_r7_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(wdata_i));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
endmodule

// File: rtl/sca_reg_bank.sv
module sca_reg_bank
  import sca_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          WIN_BITS  = 14,
  parameter logic [31:0] BASE_ADDR = 32'hFFF8_4000,
  parameter int          N_ALIAS   = 4,
  parameter int          N_PLAIN   = 2,
  parameter int          PLAIN_OFF = 'h100
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  psel_i,
  input  logic                  penable_i,
  input  logic                  pwrite_i,
  input  logic [AW-1:0]         paddr_i,
  input  logic [DW-1:0]         pwdata_i,
  output logic [DW-1:0]         prdata_o,
  output logic                  pready_o,
  output logic                  pslverr_o,
  output logic [N_ALIAS*DW-1:0] ctrl_o,
  output logic [N_PLAIN*DW-1:0] plain_o
);
  logic [N_ALIAS-1:0] hit_alias;
  logic [N_PLAIN-1:0] hit_plain;
  alias_kind_e        kind;
  logic               dec_err, acc, wr;
  logic [DW-1:0]      rdata;

  assign acc = psel_i && penable_i;
  assign wr  = acc && pwrite_i;

  sca_decode #(
    .AW(AW), .WIN_BITS(WIN_BITS), .BASE_ADDR(BASE_ADDR),
    .N_ALIAS(N_ALIAS), .N_PLAIN(N_PLAIN), .PLAIN_OFF(PLAIN_OFF)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .paddr_i(paddr_i),
    .hit_alias_o(hit_alias), .kind_o(kind),
    .hit_plain_o(hit_plain), .err_o(dec_err)
  );

  for (genvar k = 0; k < N_ALIAS; k++) begin : g_alias
    sca_alias_reg #(.DW(DW)) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_we_i(wr && hit_alias[k] && kind == K_SET),
      .clr_we_i(wr && hit_alias[k] && kind == K_CLR),
      .wdata_i(pwdata_i),
      .q_o(ctrl_o[k*DW +: DW])
    );
  end

  for (genvar j = 0; j < N_PLAIN; j++) begin : g_plain
    sca_plain_reg #(.DW(DW)) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .we_i(wr && hit_plain[j]),
      .wdata_i(pwdata_i),
      .q_o(plain_o[j*DW +: DW])
    );
  end

  // set/clear slots contribute nothing to the read mux
  always_comb begin
    rdata = '0;
    for (int k = 0; k < N_ALIAS; k++)
      if (hit_alias[k] && kind == K_RD) rdata |= ctrl_o[k*DW +: DW];
    for (int j = 0; j < N_PLAIN; j++)
      if (hit_plain[j]) rdata |= plain_o[j*DW +: DW];
  end

  assign prdata_o  = (psel_i && !pwrite_i) ? rdata : '0;
  assign pready_o  = 1'b1;
  assign pslverr_o = acc && dec_err;

  a_r8_err_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> prdata_o == '0);
  a_r8_err_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |=> $stable(ctrl_o) && $stable(plain_o));
  a_r10_setup_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(psel_i && penable_i && pwrite_i) |=> $stable(ctrl_o) && $stable(plain_o));
  a_r11_ready: assert property (@(posedge clk_i) disable iff (!rst_ni) pready_o);
endmodule

// File: tb/tb_sca_reg_bank.sv
module tb_sca_reg_bank;
  localparam int DW = 32;
  localparam int NA = 4;
  localparam int NP = 2;
  localparam logic [31:0] B = 32'hFFF8_4000;

  logic clk = 0, rst_ni = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [31:0] paddr = '0, pwdata = '0;
  logic [DW-1:0] prdata;
  logic pready, pslverr;
  logic [NA*DW-1:0] ctrl;
  logic [NP*DW-1:0] plain;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sca_reg_bank dut (
    .clk_i(clk), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr),
    .ctrl_o(ctrl), .plain_o(plain)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one two-phase transfer; err/rd captured in access phase
  task automatic xfer(input logic w, input logic [31:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic err, output logic rdy);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = w; paddr = a; pwdata = w ? d : '0;
    @(negedge clk);
    penable = 1;
    #1;
    rd = prdata; err = pslverr; rdy = pready;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  // {write, addr, data-or-expected, expected err}
  localparam int NV = 28;
  localparam logic [65:0] VEC [NV] = '{
    {1'b1, B+32'h000, 32'hA5A5_0000, 1'b0}, // R2
    {1'b0, B+32'h008, 32'hA5A5_0000, 1'b0}, // R5
    {1'b1, B+32'h000, 32'h0000_00FF, 1'b0}, // R2
    {1'b0, B+32'h008, 32'hA5A5_00FF, 1'b0}, // R4
    {1'b1, B+32'h004, 32'h0500_000F, 1'b0}, // R3
    {1'b0, B+32'h008, 32'hA0A5_00F0, 1'b0}, // R3
    {1'b0, B+32'h000, 32'h0000_0000, 1'b0}, // R5 set alias reads 0
    {1'b0, B+32'h004, 32'h0000_0000, 1'b0}, // R5 clear alias reads 0
    {1'b1, B+32'h008, 32'hFFFF_FFFF, 1'b0}, // R6
    {1'b0, B+32'h008, 32'hA0A5_00F0, 1'b0}, // R6
    {1'b0, B+32'h018, 32'h0000_0000, 1'b0}, // R4 other reg
    {1'b1, B+32'h010, 32'h1234_5678, 1'b0}, // R2
    {1'b0, B+32'h018, 32'h1234_5678, 1'b0}, // R2
    {1'b0, B+32'h008, 32'hA0A5_00F0, 1'b0}, // R4
    {1'b1, B+32'h100, 32'hDEAD_BEEF, 1'b0}, // R7
    {1'b0, B+32'h100, 32'hDEAD_BEEF, 1'b0}, // R7
    {1'b1, B+32'h104, 32'hCAFE_0001, 1'b0}, // R7
    {1'b0, B+32'h104, 32'hCAFE_0001, 1'b0}, // R7
    {1'b0, B+32'h00C, 32'h0000_0000, 1'b1}, // R8 gap
    {1'b1, B+32'h00C, 32'hFFFF_FFFF, 1'b1}, // R8
    {1'b0, B+32'h040, 32'h0000_0000, 1'b1}, // R8 past last group
    {1'b0, B+32'h108, 32'h0000_0000, 1'b1}, // R8 past plain
    {1'b0, B+32'h101, 32'h0000_0000, 1'b1}, // R8 misaligned
    {1'b0, 32'hFFF8_0008, 32'h0000_0000, 1'b1}, // R9
    {1'b1, 32'hFFF8_0000, 32'hFFFF_FFFF, 1'b1}, // R9
    {1'b0, B+32'h008, 32'hA0A5_00F0, 1'b0}, // R9 no effect
    {1'b1, B+32'h034, 32'hFFFF_FFFF, 1'b0}, // R3 clear of zero reg
    {1'b0, B+32'h038, 32'h0000_0000, 1'b0}  // R3
  };

  initial begin
    logic [31:0] rd;
    logic err, rdy;
    #2;
    // R1: held in reset
    check("R1 ctrl in reset", ctrl[31:0] | ctrl[63:32] | ctrl[95:64] | ctrl[127:96], 0);
    check("R1 plain in reset", plain[31:0] | plain[63:32], 0);
    #20 rst_ni = 1;
    @(negedge clk);
    check("R1 ctrl after reset", ctrl[31:0] | ctrl[127:96], 0);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i][65], VEC[i][64:33], VEC[i][32:1], rd, err, rdy);
      if (!VEC[i][65]) check($sformatf("R5/R8 vec %0d data", i), rd, VEC[i][32:1]);
      check($sformatf("R8/R9 vec %0d err", i), {31'b0, err}, {31'b0, VEC[i][0]});
      check("R11 ready", {31'b0, rdy}, 1);
    end

    @(negedge clk);
    check("R2 ctrl0 port", ctrl[31:0], 32'hA0A5_00F0);
    check("R2 ctrl1 port", ctrl[63:32], 32'h1234_5678);
    check("R4 ctrl2 untouched", ctrl[95:64], 0);
    check("R7 plain0 port", plain[31:0], 32'hDEAD_BEEF);
    check("R7 plain1 port", plain[63:32], 32'hCAFE_0001);

    // R10: setup phase only, never enabled
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = B + 32'h030; pwdata = 32'hFFFF_FFFF;
    @(negedge clk);
    @(negedge clk);
    psel = 0; pwrite = 0;
    @(negedge clk);
    check("R10 setup-only write", ctrl[127:96], 0);
    check("R10 plain stable", plain[31:0], 32'hDEAD_BEEF);

    // R1: asynchronous reset mid-run
    #3 rst_ni = 0;
    #1;
    check("R1 async clear ctrl0", ctrl[31:0], 0);
    check("R1 async clear plain0", plain[31:0], 0);
    #10 rst_ni = 1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule